// File: doc/BRIEF.md
# Two-Level Return Address Stack

This block keeps the return addresses of a small processor core in hardware. Software cannot see it. When the core takes a subroutine call or acknowledges an interrupt, it presents the current program counter and raises `push`. When it executes a return from subroutine or from interrupt, it raises `pop`. The saved address then appears on `pop_pc` for the program counter logic to reload. By default the stack has two levels and the program counter is 10 bits wide. Both are parameters.

The stack does not refuse a push when it is full. It drops its oldest entry and keeps the most recent addresses. A subroutine call on a full stack therefore loses the outermost return address. The `full` flag is driven combinationally from the level count. The interrupt controller uses it to hold back acknowledgment of a pending interrupt in the same cycle. Once a return frees a level, `full` falls and the deferred interrupt can be taken. A pop on an empty stack changes nothing. Asserting `push` and `pop` together performs the return and then the call, in one cycle.

Top module: `ret_addr_stack`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) leaves the stack with `empty`=1, `full`=0 and `pop_pc`=0.
- R2: Pushes and pops follow last-in first-out order. A pop sampled at a clock edge puts the most recently pushed, still-held address on `pop_pc` after that edge. A push on a stack that is not full adds one level.
- R3: `full` is 1 exactly when all DEPTH levels (2 by default) are occupied. `empty` is 1 exactly when no level is occupied. The two flags are never 1 together, and the level count never exceeds DEPTH.
- R4: A push with no pop on a full stack discards the oldest entry and keeps the stack full. The following pops return the DEPTH most recent addresses, newest first.
- R5: A pop on an empty stack leaves `pop_pc` at the last value it returned and leaves the stack empty.
- R6: `push` and `pop` together on a non-empty stack return the old top on `pop_pc` and replace the top with `push_pc`, with the level count unchanged. On an empty stack the pair acts as a plain push and `pop_pc` holds.
- R7: A pop without a push on a full stack clears `full` after that clock edge. This releases a deferred interrupt acknowledgment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Save `push_pc` (subroutine call or interrupt acknowledge) |
| pop | input | 1 | Restore the newest saved address (return) |
| push_pc | input | PC_W | Program counter value to save |
| pop_pc | output | PC_W | Address returned by the most recent effective pop |
| full | output | 1 | All levels occupied (combinational from the level count) |
| empty | output | 1 | No level occupied |

## Verification
The bench builds the block with its defaults: two levels and a 10-bit program counter. At that size every sequence of five operations drawn from idle, push, pop and push-with-pop can be applied from reset, which gives 1024 sequences. Each sequence is followed by draining pops. The sweep therefore covers every order of overflowing pushes, pops on an empty stack, simultaneous operations at each fill level and the release of `full`. A small arithmetic model in the bench predicts `pop_pc` and both flags after every edge.

// File: rtl/ras_pkg.sv
// ras_pkg: shared types for the return address stack.
// The control decoder produces one effective operation per cycle.
// The level counter, the entry store and the output register all act on it.
package ras_pkg;

    // Effective stack operation after the empty-pop filter has been applied.
    typedef enum logic [1:0] {
        RAS_IDLE = 2'd0,   // nothing changes
        RAS_PUSH = 2'd1,   // add a new top (drops the oldest entry when full)
        RAS_POP  = 2'd2,   // remove the top and return it
        RAS_SWAP = 2'd3    // return the top and replace it in the same cycle
    } ras_op_e;

endpackage

// File: rtl/ras_ctrl.sv
// ras_ctrl: turns the raw push/pop requests into one effective operation.
// A pop on an empty stack is discarded here, so later stages never see
// a pop they cannot serve.
// Assumes: `empty` comes from the level counter of the same stack.
module ras_ctrl
    import ras_pkg::*;
(
    input  logic    push,
    input  logic    pop,
    input  logic    empty,
    output ras_op_e op
);

    logic pop_ok;

    // Filter: a pop only counts when something is stored.
    always_comb pop_ok = pop & ~empty;

    // Decode the request pair into the effective operation.
    always_comb begin
        unique case ({push, pop_ok})
            2'b11:   op = RAS_SWAP;
            2'b10:   op = RAS_PUSH;
            2'b01:   op = RAS_POP;
            default: op = RAS_IDLE;
        endcase
    end

endmodule

// File: rtl/ras_level.sv
// ras_level: counts the occupied levels and derives the full/empty flags.
// The count saturates at DEPTH. A push on a full stack overwrites the
// oldest entry instead of growing the count. The flags are combinational
// from the count, so the interrupt logic can gate acknowledgment in the
// same cycle.
// Assumes: `op` never carries a pop while the count is zero (see ras_ctrl).
module ras_level
    import ras_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  ras_op_e op,
    output logic    full,
    output logic    empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] count;

    // Level counter: up on a push (saturating), down on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                RAS_PUSH: if (count != FULL_CNT) count <= count + ONE;
                RAS_POP:  count <= count - ONE;
                default:  count <= count;
            endcase
        end
    end

    // Flags decoded straight from the count.
    always_comb begin
        full  = (count == FULL_CNT);
        empty = (count == '0);
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R3
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R2
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RAS_PUSH && !full) |=> (count == $past(count) + ONE));

    // R4
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RAS_PUSH && full) |=> full);

    // R6
    swap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RAS_SWAP) |=> $stable(count));

endmodule

// File: rtl/ras_store.sv
// ras_store: the return address entries, kept as a shift register.
// Entry 0 is always the top. A push shifts every entry one place deeper,
// so the deepest (oldest) entry falls off the end when the stack is full.
// A pop shifts every entry one place toward the top.
// Assumes: `op` has already been filtered by ras_ctrl.
module ras_store
    import ras_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int PC_W  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ras_op_e         op,
    input  logic [PC_W-1:0] push_pc,
    output logic [PC_W-1:0] top_pc
);

    logic [PC_W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Value shifted in from the shallower neighbour on a push.
        logic [PC_W-1:0] from_up;
        // Value shifted in from the deeper neighbour on a pop.
        logic [PC_W-1:0] from_down;

        if (i == 0) begin : g_top
            // The top takes the new address on a push.
            always_comb from_up = push_pc;
        end else begin : g_mid
            // Deeper entries take the shallower neighbour on a push.
            always_comb from_up = ent[i-1];
        end

        if (i == DEPTH - 1) begin : g_bot
            // The bottom level is cleared as it empties.
            always_comb from_down = '0;
        end else begin : g_upper
            // Other levels take the deeper neighbour on a pop.
            always_comb from_down = ent[i+1];
        end

        // Entry register: shift on push/pop; a swap rewrites only the top.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[i] <= '0;
            end else begin
                unique case (op)
                    RAS_PUSH: ent[i] <= from_up;
                    RAS_POP:  ent[i] <= from_down;
                    RAS_SWAP: if (i == 0) ent[i] <= push_pc;
                    default:  ent[i] <= ent[i];
                endcase
            end
        end
    end

    // The top entry feeds the output register.
    always_comb top_pc = ent[0];

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RAS_PUSH || op == RAS_SWAP) |=> (top_pc == $past(push_pc)));

endmodule

// File: rtl/ras_outreg.sv
// ras_outreg: holds the address returned by the latest effective pop.
// It changes only on a pop or a swap. A filtered (empty) pop leaves the
// previous value in place.
// Assumes: `top_pc` is the store's top entry before the edge.
module ras_outreg
    import ras_pkg::*;
#(
    parameter int PC_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ras_op_e         op,
    input  logic [PC_W-1:0] top_pc,
    output logic [PC_W-1:0] pop_pc
);

    // Capture the top entry when it is popped or swapped out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_pc <= '0;
        end else if (op == RAS_POP || op == RAS_SWAP) begin
            pop_pc <= top_pc;
        end
    end

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RAS_IDLE || op == RAS_PUSH) |=> $stable(pop_pc));

endmodule

// File: rtl/ret_addr_stack.sv
// ret_addr_stack: hardware return address stack for calls and interrupts.
// A push saves push_pc; a pop returns the newest saved address on pop_pc
// after the edge. A push on a full stack drops the oldest entry. A pop on
// an empty stack is ignored. `full` is combinational so that interrupt
// acknowledgment can be deferred in the same cycle.
// Assumes: the caller gates interrupt acknowledgment (push) with `full`;
// a subroutine call may push at any time.
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int PC_W  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_pc,
    output logic [PC_W-1:0] pop_pc,
    output logic            full,
    output logic            empty
);

    ras_op_e         op;
    logic [PC_W-1:0] top_pc;

    ras_ctrl u_ctrl (
        .push  (push),
        .pop   (pop),
        .empty (empty),
        .op    (op)
    );

    ras_level #(.DEPTH(DEPTH)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .full  (full),
        .empty (empty)
    );

    ras_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .push_pc (push_pc),
        .top_pc  (top_pc)
    );

    ras_outreg #(.PC_W(PC_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .top_pc (top_pc),
        .pop_pc (pop_pc)
    );

    // R2
    pop_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> (pop_pc == $past(top_pc)));

    // R7
    full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && full) |=> !full);

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (empty && $stable(pop_pc)));

endmodule

// File: tb/tb_ret_addr_stack.sv
// tb_ret_addr_stack: sweeps every five-step sequence of idle / push /
// pop / push+pop from reset, then drains the stack. A small model
// predicts pop_pc, full and empty after every edge.
module tb_ret_addr_stack;

    localparam int DEPTH = 2;
    localparam int PC_W  = 10;
    localparam int STEPS = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            push = 1'b0;
    logic            pop = 1'b0;
    logic [PC_W-1:0] push_pc = '0;
    logic [PC_W-1:0] pop_pc;
    logic            full;
    logic            empty;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state
    logic [PC_W-1:0] m0, m1, mlast;
    int              mcnt;

    ret_addr_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_pc(push_pc), .pop_pc(pop_pc), .full(full), .empty(empty)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push = 1'b0; pop = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m0 = '0; m1 = '0; mlast = '0; mcnt = 0;
        // R1: reset state
        check("R1", "empty", 32'(empty), 32'd1);
        check("R1", "full", 32'(full), 32'd0);
        check("R1", "pop_pc", 32'(pop_pc), 32'd0);
    endtask

    // Apply one operation at a negedge, update the model, check after the edge.
    task automatic step(input bit ps, input bit pp, input logic [PC_W-1:0] pc);
        string tag;
        bit    was_full;
        was_full = (mcnt == DEPTH);
        if (pp && mcnt == 0)            tag = "R5";
        else if (ps && pp)              tag = "R6";
        else if (ps && was_full)        tag = "R4";
        else if (pp && was_full && !ps) tag = "R7";
        else                            tag = "R2";
        if (pp && mcnt != 0) begin
            mlast = m0;
            if (ps) m0 = pc;
            else begin m0 = m1; m1 = '0; mcnt--; end
        end else if (ps) begin
            m1 = m0; m0 = pc;
            if (mcnt < DEPTH) mcnt++;
        end
        push = ps; pop = pp; push_pc = pc;
        @(posedge clk);
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        check(tag, "pop_pc", 32'(pop_pc), 32'(mlast));
        // R3: flags follow the level count
        check("R3", "empty", 32'(empty), 32'(mcnt == 0));
        check("R3", "full", 32'(full), 32'(mcnt == DEPTH));
    endtask

    initial begin
        for (int s = 0; s < (1 << (2 * STEPS)); s++) begin
            do_reset();
            for (int k = 0; k < STEPS; k++) begin
                logic [1:0] code;
                code = 2'((s >> (2 * k)) & 3);
                step(code[0], code[1], PC_W'(s * 7 + k * 131 + 5));
            end
            // R2 / R4: drain, newest first
            for (int d = 0; d < DEPTH + 1; d++) step(1'b0, 1'b1, '0);
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule